// File: doc/BRIEF.md
# Synthesizer Enable and Settle Sequencer

This block sits between the board-level control pins of a spread-spectrum clock synthesizer and its analog core. It takes an enable pin, the raw setting pins (frequency multiply select, spread direction, and a two-bit spread depth) and a free-running one-microsecond timebase tick. From these it derives a power-down request for the core, a high-impedance control for the clock output pad, the setting values the core actually uses, and a clock-valid flag. The clock-valid flag is meant to hold logic downstream of the synthesizer in reset.

When the enable pin goes low and stays low long enough, the core is powered down, the output pad floats, and every internal setting is driven to zero. When enable returns, or when any setting pin settles at a new value, the PLL needs a lock-up wait of the worst-case lock time (10 ms, counted as 10000 ticks by default). Clock-valid only rises after that wait has run out with no further disturbance. Setting pins pass through a synchronizer and are accepted only once a value has been seen on two consecutive ticks. An enable-low pulse that spans only one tick is discarded.

Top module: `synth_enable_seq`

## Requirements
- R1: An enable-low level seen on two consecutive ticks asserts pwrDownReq and outHighZ (both 1). With a tick on every clock, they rise at the fifth rising clock edge after the pin falls.
- R2: While pwrDownReq is 1, multOut, spreadOut and depthOut are all 0, whatever the setting pins hold.
- R3: An enable-low pulse seen on only one tick has no effect: pwrDownReq stays 0 and clockValid stays 1.
- R4: After power-down is left, clockValid rises only once LOCK_TICKS ticks have been counted in the settling state. With a tick on every clock, that is at the 4+LOCK_TICKS-th rising edge after enable rises.
- R5: A new setting held for two consecutive ticks is taken up. The setting outputs show it at the fourth rising edge after the pin change, and clockValid falls at the fifth. Setting order on the packed bus is {multiply, spread, depth[1:0]}.
- R6: A setting value seen on only one tick is ignored: the setting outputs keep their value and clockValid stays 1.
- R7: A setting change accepted during the settling wait clears the wait counter, so clockValid rises LOCK_TICKS+5 edges after the latest change.
- R8: While asynchronous reset is active, pwrDownReq=1, outHighZ=1, clockValid=0 and all setting outputs are 0.
- R9: In steady operation the setting outputs equal the setting pins and pwrDownReq is 0.
- R10: When power-down is left, pwrDownReq and outHighZ drop at the fourth rising edge after enable rises, while clockValid is still 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe, nominally every 1 us |
| enableIn | input | 1 | Raw output-enable pin (1 = run) |
| multIn | input | 1 | Raw multiply-select pin |
| spreadIn | input | 1 | Raw spread-direction pin |
| depthIn | input | 2 | Raw spread-depth pins |
| pwrDownReq | output | 1 | Power-down request to the synthesizer core |
| outHighZ | output | 1 | 1 puts the clock output pad in high impedance |
| multOut | output | 1 | Internal multiply select |
| spreadOut | output | 1 | Internal spread direction |
| depthOut | output | 2 | Internal spread depth |
| clockValid | output | 1 | 1 once the lock-up wait has finished |

## Verification
A sequencer stuck in the wrong state shows up at once on pwrDownReq and clockValid, because both are decoded straight from the state. A counter that does not clear, or a terminal count that is off, moves the clockValid rising edge by whole ticks. The bench therefore pins that edge to one exact clock cycle. A broken glitch filter shows within five edges, either as a spurious power-down or as a setting output that moves on a one-tick pulse.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_VALID  = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic forceLow;
  } seqStrobe_t;

  // Packed order matters: {multiply, spread, depth}
  typedef struct packed {
    logic       mult;
    logic       spread;
    logic [1:0] depth;
  } synthSet_t;

  localparam int SET_W = $bits(synthSet_t);

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int LOCK_TICKS  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enableRaw,
  input  synthSet_t  setRaw,
  input  seqStrobe_t strobe,
  output logic       enOn,
  output logic       setChg,
  output logic       cntDone,
  output synthSet_t  setOut
);

  localparam int BUS_W = SET_W + 1;
  localparam int CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_TICKS - 1);

  // ---------------- synchronizer ----------------
  logic [BUS_W-1:0] syncPipe [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[0] <= '0;
        else       syncPipe[0] <= {enableRaw, setRaw};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  logic      syncEn;
  synthSet_t syncSet;
  assign syncEn  = syncPipe[SYNC_STAGES-1][BUS_W-1];
  assign syncSet = synthSet_t'(syncPipe[SYNC_STAGES-1][SET_W-1:0]);

  // ---------------- enable low-width filter ----------------
  logic lowPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPrev <= 1'b0;
      enOn    <= 1'b0;
    end else if (tick) begin
      lowPrev <= ~syncEn;
      if (syncEn)       enOn <= 1'b1;
      else if (lowPrev) enOn <= 1'b0;
    end
  end

  // ---------------- setting two-tick filter ----------------
  synthSet_t candSet;
  synthSet_t stableSet;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candSet   <= '0;
      stableSet <= '0;
      setChg    <= 1'b0;
    end else begin
      setChg <= 1'b0;
      if (tick) begin
        candSet <= syncSet;
        if ((syncSet == candSet) && (syncSet != stableSet)) begin
          stableSet <= syncSet;
          setChg    <= 1'b1;
        end
      end
    end
  end

  assign setOut = strobe.forceLow ? synthSet_t'('0) : stableSet;

  // ---------------- lock wait counter ----------------
  logic [CNT_W-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.cntClear) begin
      waitCnt <= '0;
    end else if (strobe.cntRun && tick && (waitCnt != CNT_LAST)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign cntDone = strobe.cntRun && tick && (waitCnt == CNT_LAST);

  // Counter never passes its terminal value (R4)
  assert_no_overflow_R4 : assert property (
    @(posedge clk) disable iff (!rstN) waitCnt <= CNT_LAST
  );

  // An accepted change always carries a new setting value (R5)
  assert_change_is_new_R5 : assert property (
    @(posedge clk) disable iff (!rstN) setChg |-> (stableSet != $past(stableSet))
  );

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enOn,
  input  logic       setChg,
  input  logic       cntDone,
  output seqStrobe_t strobe,
  output logic       pwrDownReq,
  output logic       outHighZ,
  output logic       clockValid
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF: begin
        if (enOn) stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!enOn)        stateNext = ST_OFF;
        else if (setChg)  stateNext = ST_SETTLE;
        else if (cntDone) stateNext = ST_VALID;
      end
      ST_VALID: begin
        if (!enOn)       stateNext = ST_OFF;
        else if (setChg) stateNext = ST_SETTLE;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.cntClear = (state == ST_OFF) || setChg;
    strobe.cntRun   = (state == ST_SETTLE);
    strobe.forceLow = (state == ST_OFF);
  end

  assign pwrDownReq = (state == ST_OFF);
  assign outHighZ   = (state == ST_OFF);
  assign clockValid = (state == ST_VALID);

  // Valid only rises on the cycle after the counter reports its end (R4)
  assert_valid_after_wait_R4 : assert property (
    @(posedge clk) disable iff (!rstN) $rose(clockValid) |-> $past(cntDone)
  );

  // Power-down is entered only from a filtered enable-low (R1)
  assert_pd_needs_low_R1 : assert property (
    @(posedge clk) disable iff (!rstN) $rose(pwrDownReq) |-> $past(!enOn)
  );

  // A change always drops the valid flag on the next cycle (R5)
  assert_change_drops_valid_R5 : assert property (
    @(posedge clk) disable iff (!rstN) (setChg && enOn) |=> !clockValid
  );

endmodule

// File: rtl/synth_enable_seq.sv
module synth_enable_seq
  import seq_pkg::*;
#(
  parameter int LOCK_TICKS  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enableIn,
  input  logic       multIn,
  input  logic       spreadIn,
  input  logic [1:0] depthIn,
  output logic       pwrDownReq,
  output logic       outHighZ,
  output logic       multOut,
  output logic       spreadOut,
  output logic [1:0] depthOut,
  output logic       clockValid
);

  seqStrobe_t strobe;
  synthSet_t  setRaw, setOut;
  logic       enOn, setChg, cntDone;

  assign setRaw = '{mult: multIn, spread: spreadIn, depth: depthIn};

  seq_datapath #(
    .LOCK_TICKS (LOCK_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .enableRaw(enableIn),
    .setRaw   (setRaw),
    .strobe   (strobe),
    .enOn     (enOn),
    .setChg   (setChg),
    .cntDone  (cntDone),
    .setOut   (setOut)
  );

  seq_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .enOn      (enOn),
    .setChg    (setChg),
    .cntDone   (cntDone),
    .strobe    (strobe),
    .pwrDownReq(pwrDownReq),
    .outHighZ  (outHighZ),
    .clockValid(clockValid)
  );

  assign multOut   = setOut.mult;
  assign spreadOut = setOut.spread;
  assign depthOut  = setOut.depth;

  // Settings are zero whenever the core is powered down (R2)
  assert_off_forces_low_R2 : assert property (
    @(posedge clk) disable iff (!rstN)
      pwrDownReq |-> ({multOut, spreadOut, depthOut} == 4'b0000)
  );

endmodule

// File: tb/test_synth_enable_seq.sv
module test_synth_enable_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic enableIn = 1'b1;
  logic multIn = 1'b0, spreadIn = 1'b0;
  logic [1:0] depthIn = 2'b00;
  logic pwrDownReq, outHighZ, multOut, spreadOut, clockValid;
  logic [1:0] depthOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_enable_seq #(.LOCK_TICKS(LT)) i_synth_enable_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .enableIn(enableIn),
    .multIn(multIn), .spreadIn(spreadIn), .depthIn(depthIn),
    .pwrDownReq(pwrDownReq), .outHighZ(outHighZ), .multOut(multOut),
    .spreadOut(spreadOut), .depthOut(depthOut), .clockValid(clockValid)
  );

  // {en, set[3:0], expPd, expValid, expSet[3:0]}; set = {mult, spread, depth}
  localparam logic [10:0] VECS [0:4] = '{
    11'b1_1011_0_1_1011,
    11'b1_0101_0_1_0101,
    11'b0_1111_1_0_0000,
    11'b1_1111_0_1_1111,
    11'b1_0000_0_1_0000
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic setPins(logic [3:0] v);
    {multIn, spreadIn, depthIn} = v;
  endtask

  function automatic logic [3:0] outSet();
    return {multOut, spreadOut, depthOut};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    setPins(4'b1010);
    #(CLK_PERIOD * 3);
    // R8: reset state
    chk("R8 pd", pwrDownReq, 1);
    chk("R8 hiz", outHighZ, 1);
    chk("R8 valid", clockValid, 0);
    chk("R8 set", outSet(), 0);
    @(negedge clk) rstN = 1'b1;

    // Steady-state vector walk (R9, R2)
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      enableIn = VECS[i][10];
      setPins(VECS[i][9:6]);
      waitEdges(LT + 40);
      chk("R9 pd", pwrDownReq, VECS[i][5]);
      chk("R9 valid", clockValid, VECS[i][4]);
      chk("R9/R2 set", outSet(), VECS[i][3:0]);
    end

    // R10 / R4: exact timing out of power-down
    @(negedge clk) enableIn = 1'b0;
    waitEdges(20);
    chk("R1 pd held", pwrDownReq, 1);
    @(negedge clk) enableIn = 1'b1;
    waitEdges(3);
    chk("R10 pd before", pwrDownReq, 1);
    waitEdges(1);
    chk("R10 pd released", pwrDownReq, 0);
    chk("R10 hiz released", outHighZ, 0);
    chk("R10 valid low", clockValid, 0);
    waitEdges(LT - 1);
    chk("R4 valid early", clockValid, 0);
    waitEdges(1);
    chk("R4 valid on time", clockValid, 1);

    // R3: one-cycle enable glitch ignored
    @(negedge clk) enableIn = 1'b0;
    @(negedge clk) enableIn = 1'b1;
    for (int k = 0; k < 10; k++) begin
      waitEdges(1);
      chk("R3 valid kept", clockValid, 1);
      chk("R3 pd kept", pwrDownReq, 0);
    end

    // R5: setting change restarts the wait
    @(negedge clk) setPins(4'b0110);
    waitEdges(3);
    chk("R5 set old", outSet(), 4'b0000);
    chk("R5 valid still", clockValid, 1);
    waitEdges(1);
    chk("R5 set new", outSet(), 4'b0110);
    waitEdges(1);
    chk("R5 valid dropped", clockValid, 0);
    waitEdges(LT - 1);
    chk("R5 valid early", clockValid, 0);
    waitEdges(1);
    chk("R5 valid back", clockValid, 1);

    // R6: one-cycle setting glitch ignored
    @(negedge clk) setPins(4'b1001);
    @(negedge clk) setPins(4'b0110);
    for (int k = 0; k < 10; k++) begin
      waitEdges(1);
      chk("R6 valid kept", clockValid, 1);
      chk("R6 set kept", outSet(), 4'b0110);
    end

    // R7: change during settling restarts the count
    @(negedge clk) setPins(4'b0011);
    waitEdges(10);
    chk("R7 settling", clockValid, 0);
    @(negedge clk) setPins(4'b1100);
    waitEdges(LT + 4);
    chk("R7 valid early", clockValid, 0);
    waitEdges(1);
    chk("R7 valid on time", clockValid, 1);
    chk("R7 set", outSet(), 4'b1100);

    // R1 / R2: two-cycle enable low gives power-down at edge 5
    @(negedge clk) enableIn = 1'b0;
    waitEdges(4);
    chk("R1 pd before", pwrDownReq, 0);
    waitEdges(1);
    chk("R1 pd", pwrDownReq, 1);
    chk("R1 hiz", outHighZ, 1);
    chk("R2 set low", outSet(), 0);
    @(negedge clk) setPins(4'b1111);
    waitEdges(10);
    chk("R2 set low while off", outSet(), 0);
    chk("R2 valid low while off", clockValid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule